// File: doc/BRIEF.md
# Level-Encoded Dual-Rail to Return-to-Zero Dual-Rail Input Converter

This block sits at the input of a function block that computes in a four-phase, return-to-zero dual-rail style. Its input bus uses a two-wire-per-bit, alternating-phase code. In that code the value wire always holds the bit itself. The second wire is chosen so that the XOR of the two wires flips from one item to the next. As a result, each new item moves exactly one of the two wires of every bit. The converter is modelled cycle by cycle on a clock.

Each bit gets a phase flag, which is the XOR of its two wires. A word-phase register follows the input only when every bit has reached the same phase, and it holds its value while the bits disagree. The surrounding control logic watches this register to know when a whole new word has arrived. It then raises the enable input. While enable is high, each bit drives one of its true and false rails high, chosen by the value wire. While enable is low, all rails sit at zero, which is the spacer. Per-bit and whole-word four-phase completion outputs report when the rails hold valid data and when they have returned to the spacer.

Top module: `ledr_rz_conv`

## Requirements
- R1: Output `bit_phase[i]` equals `ledr_dat[i] XOR ledr_par[i]`. A value of 0 means even phase and 1 means odd phase.
- R2: While `en` is 1, `rail_t[i]` equals `ledr_dat[i]` and `rail_f[i]` equals its inverse, so exactly one rail of each bit is high.
- R3: While `en` is 0, every `rail_t` and `rail_f` bit is 0, whatever the input wires hold.
- R4: `word_phase` becomes 1 on the clock edge after all bits are in odd phase. It becomes 0 on the edge after all bits are in even phase.
- R5: When the bits are in mixed phases, `word_phase` keeps its value across the next edge.
- R6: While `rst_n` is low, `word_phase` and `all_valid` are 0, which is even phase and spacer.
- R7: `bit_valid[i]` is the OR of `rail_t[i]` and `rail_f[i]`.
- R8: `all_valid` becomes 1 on the edge after every bit is valid. It becomes 0 on the edge after every bit is spacer. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Evaluate (1) or return to spacer (0) |
| ledr_dat | input | W | Value wire of each input bit |
| ledr_par | input | W | Phase wire of each input bit |
| rail_t | output | W | True rail of each dual-rail bit |
| rail_f | output | W | False rail of each dual-rail bit |
| bit_phase | output | W | Phase of each input bit |
| word_phase | output | 1 | Registered phase of the last complete word |
| bit_valid | output | W | Per-bit four-phase completion |
| all_valid | output | 1 | Registered whole-word four-phase completion |

## Verification
The bench sends streams of random words in the alternating-phase code. These streams include repeated values, so some items move only the phase wire and some move only the value wire. This separates a phase detector that uses the XOR from one that only watches the value wire. It also sends words where only some bits have moved on to the new phase. These show that a partial arrival never moves the word phase, while the final bit that completes the word does. The enable input is toggled between items and held low while the data changes, to separate correct spacer gating from any leak of input data onto the rails.

// File: rtl/ledr_rz_conv.sv
module ledr_rz_conv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ledr_dat,
  input  logic [W-1:0] ledr_par,
  output logic [W-1:0] rail_t,
  output logic [W-1:0] rail_f,
  output logic [W-1:0] bit_phase,
  output logic         word_phase,
  output logic [W-1:0] bit_valid,
  output logic         all_valid
);

  assign bit_phase = ledr_dat ^ ledr_par;
  assign rail_t    = {W{en}} & ledr_dat;
  assign rail_f    = {W{en}} & ~ledr_dat;
  assign bit_valid = rail_t | rail_f;

  logic all_odd, all_even, all_set, all_clr;
  assign all_odd  = &bit_phase;
  assign all_even = ~|bit_phase;
  assign all_set  = &bit_valid;
  assign all_clr  = ~|bit_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_phase <= 1'b0;
      all_valid  <= 1'b0;
    end else begin
      if (all_odd)       word_phase <= 1'b1;
      else if (all_even) word_phase <= 1'b0;
      if (all_set)       all_valid <= 1'b1;
      else if (all_clr)  all_valid <= 1'b0;
    end
  end

endmodule

module ledr_rz_conv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] ledr_dat,
  input logic [W-1:0] ledr_par,
  input logic [W-1:0] rail_t,
  input logic [W-1:0] rail_f,
  input logic         word_phase,
  input logic         all_valid
);

  assert_onehot_rails_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((rail_t ^ rail_f) == {W{1'b1}}) && ((rail_t & rail_f) == '0));

  assert_spacer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rail_t == '0) && (rail_f == '0));

  assert_odd_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ledr_dat ^ ledr_par) == {W{1'b1}}) |=> word_phase);

  assert_even_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ledr_dat ^ ledr_par) == '0) |=> !word_phase);

  assert_mixed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((ledr_dat ^ ledr_par) != '0) && ((ledr_dat ^ ledr_par) != {W{1'b1}}))
      |=> $stable(word_phase));

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> all_valid);

  assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !all_valid);

endmodule

bind ledr_rz_conv ledr_rz_conv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ledr_dat(ledr_dat), .ledr_par(ledr_par),
  .rail_t(rail_t), .rail_f(rail_f), .word_phase(word_phase), .all_valid(all_valid)
);

// File: tb/ledr_rz_conv_tb.sv
module ledr_rz_conv_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [W-1:0] ledr_dat = '0;
  logic [W-1:0] ledr_par = '0;
  logic [W-1:0] rail_t, rail_f, bit_phase, bit_valid;
  logic word_phase, all_valid;

  always #2 clk = ~clk;

  ledr_rz_conv #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ledr_dat(ledr_dat), .ledr_par(ledr_par),
    .rail_t(rail_t), .rail_f(rail_f), .bit_phase(bit_phase),
    .word_phase(word_phase), .bit_valid(bit_valid), .all_valid(all_valid)
  );

  int n_chk = 0;
  int n_err = 0;
  bit m_wp = 0;
  bit m_av = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] d, input logic [W-1:0] p, input bit e);
    int ones;
    @(negedge clk);
    ledr_dat = d; ledr_par = p; en = e;
    #1;
    for (int i = 0; i < W; i++) begin
      chk("R1", {7'b0, bit_phase[i]}, {7'b0, d[i] ^ p[i]});
      chk(e ? "R2" : "R3", {6'b0, rail_t[i], rail_f[i]}, e ? {6'b0, d[i], !d[i]} : 8'h00);
      chk("R7", {7'b0, bit_valid[i]}, {7'b0, e});
    end
    ones = 0;
    for (int i = 0; i < W; i++) ones += int'(d[i] ^ p[i]);
    @(posedge clk);
    if (ones == W) m_wp = 1;
    else if (ones == 0) m_wp = 0;
    m_av = e;
    #1;
    chk((ones == 0 || ones == W) ? "R4" : "R5", {7'b0, word_phase}, {7'b0, m_wp});
    chk("R8", {7'b0, all_valid}, {7'b0, m_av});
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w, m;
    bit ph;
    void'($urandom(17));
    ledr_dat = 8'hA5; ledr_par = 8'h0F; en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6", {7'b0, word_phase}, 8'h00);
    chk("R6", {7'b0, all_valid}, 8'h00);
    ledr_dat = '0; ledr_par = '0; en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    ph = 0;
    for (int k = 0; k < 40; k++) begin
      ph = !ph;
      w = (k % 5 == 2) ? ledr_dat : W'($urandom);
      step(w, w ^ {W{ph}}, 1'b1);
      step(w, w ^ {W{ph}}, 1'b0);
    end

    for (int k = 0; k < 20; k++) begin
      w = W'($urandom);
      m = W'($urandom) | 8'h01;
      m[W-1] = 1'b0;
      step(w, w ^ ({W{ph}} ^ m), k[0]);
      step(w, w ^ ({W{ph}} ^ m), 1'b0);
      ph = !ph;
      step(w, w ^ {W{ph}}, 1'b1);
    end

    for (int k = 0; k < 10; k++) begin
      w = W'($urandom);
      step(w, w ^ {W{ph}}, 1'b0);
      step(~w, ~w ^ {W{ph}}, 1'b0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule